// File: doc/BRIEF.md
# Trigger-Positioned Circular Capture Buffer

This block is the sample store of an on-chip logic analyzer. Once armed, it writes the probe bus into a circular memory on every clock, and the newest sample replaces the oldest after the memory has filled. A separate trigger unit delivers a one-cycle trigger pulse. A mode chosen at arm time sets how many samples are kept after the trigger: most of the window, half of it, or a small tail. A continuous mode ignores the trigger altogether and keeps sampling until a stop pulse.

When capture completes, the block freezes. A host then walks an index from 0 upward on the readout port and receives the kept samples oldest first. It also reads the number of valid samples, whether a trigger was taken, and the physical slot that holds the trigger sample.

The controller has four states. `ST_IDLE` holds after reset. `ST_PRETRIG` samples while waiting for a trigger or, in continuous mode, for a stop. `ST_POSTTRIG` samples the post-trigger tail. `ST_FROZEN` holds the completed capture. The transitions are:
- arm from any state to `ST_PRETRIG`;
- trig from `ST_PRETRIG` to `ST_POSTTRIG`;
- stop from `ST_PRETRIG` to `ST_FROZEN`, in continuous mode only;
- last tail write from `ST_POSTTRIG` to `ST_FROZEN`.

Top module: `trig_capture_buf`

## Requirements
- R1: A cycle with `arm`=1 restarts capture. On the next cycle `armed`=1, `done`=0, `valid_cnt`=0 and `trig_hit`=0. `mode` is sampled only on the arm cycle, and later changes to it have no effect on that capture.
- R2: In the cycles after an arm, one probe sample is written per clock while `armed`=1. `valid_cnt` counts the writes and saturates at DEPTH. Once DEPTH samples are held, each new write overwrites the oldest.
- R3: Mode encoding is 0 = mostly-after, 1 = centred, 2 = mostly-before, 3 = continuous. The post-trigger write count is floor(DEPTH*88/100) in mode 0, floor(DEPTH/2) in mode 1 and floor(DEPTH*12/100) in mode 2. The trigger sample itself belongs to the pre-trigger part.
- R4: A trigger pulse taken while waiting sets `trig_hit`=1. It also sets `trig_addr` to the physical slot of the trigger sample, which equals the number of samples written before it modulo DEPTH.
- R5: `done` rises, and `armed` falls, on the cycle after the final post-trigger sample is written.
- R6: While `done`=1 and no arm is given, no write occurs. `rd_data`, `valid_cnt` and `trig_addr` stay unchanged regardless of `probe`, `trig` and `stop`.
- R7: Readout index i (0 to `valid_cnt`-1) returns the i-th oldest kept sample. When the buffer is full, index 0 maps to the slot after the last write, and higher indices wrap modulo DEPTH.
- R8: A trigger that comes before DEPTH samples have been written is still taken. `valid_cnt` then reports the number written, and index 0 maps to slot 0.
- R9: In continuous mode, `trig` is ignored and `trig_hit` stays 0. Sampling continues until a `stop` pulse. The stop cycle itself is not written, and `done` rises on the next cycle.
- R10: In modes 0 to 2, `stop` has no effect.
- R11: An arm given during a capture discards it. The next capture holds only samples written after the new arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Start a new capture |
| stop | input | 1 | End capture (continuous mode only) |
| trig | input | 1 | One-cycle trigger pulse from the trigger unit |
| mode | input | 2 | Position mode, sampled on arm |
| probe | input | PROBE_W | Probe bus |
| rd_idx | input | AW | Readout index in time order, 0 = oldest |
| armed | output | 1 | Capture in progress |
| done | output | 1 | Capture complete and frozen |
| trig_hit | output | 1 | A trigger was taken in this capture |
| trig_addr | output | AW | Physical slot of the trigger sample |
| valid_cnt | output | CW | Number of valid samples held |
| rd_data | output | PROBE_W | Sample at `rd_idx` |

## Verification
The bench builds the block with DEPTH=20 and PROBE_W=12. Because the depth is not a power of two, the modulo wrap of both the write pointer and the readout map is exercised. The split ratios round down to post counts of 17, 10 and 2, so the floor rounding of each mode is checked against a non-trivial result. The short depth also lets random trigger positions fall either before the buffer fills or after several wraps, and lets continuous captures stop both short of and past a full buffer.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        MODE_AFTER  = 2'd0,
        MODE_CENTER = 2'd1,
        MODE_BEFORE = 2'd2,
        MODE_CONT   = 2'd3
    } cap_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRETRIG,
        ST_POSTTRIG,
        ST_FROZEN
    } cap_state_e;
endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
    import cap_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int CW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          stop,
    input  logic          trig,
    input  logic [1:0]    mode_in,
    input  logic [AW-1:0] wr_ptr,
    output logic          wr_en,
    output logic          armed,
    output logic          done,
    output logic          trig_hit,
    output logic [AW-1:0] trig_addr,
    output cap_mode_e     cur_mode
);
    localparam int TAIL_AFTER  = (DEPTH * 88) / 100;
    localparam int TAIL_CENTER = DEPTH / 2;
    localparam int TAIL_BEFORE = (DEPTH * 12) / 100;

    cap_state_e    state_q, state_d;
    cap_mode_e     mode_q;
    logic [CW-1:0] remain_q;
    logic [CW-1:0] tail_len;
    logic          stop_now;
    logic          take_trig;

    always_comb begin
        unique case (mode_q)
            MODE_AFTER:  tail_len = CW'(TAIL_AFTER);
            MODE_CENTER: tail_len = CW'(TAIL_CENTER);
            MODE_BEFORE: tail_len = CW'(TAIL_BEFORE);
            MODE_CONT:   tail_len = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (arm) begin
            state_d = ST_PRETRIG;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_PRETRIG: begin
                    if (stop_now)       state_d = ST_FROZEN;
                    else if (take_trig) state_d = ST_POSTTRIG;
                end
                ST_POSTTRIG: if (remain_q == CW'(1)) state_d = ST_FROZEN;
                ST_FROZEN:   state_d = ST_FROZEN;
            endcase
        end
    end

    // outputs
    always_comb begin
        stop_now  = (state_q == ST_PRETRIG) && (mode_q == MODE_CONT) && stop;
        take_trig = !arm && (state_q == ST_PRETRIG) && (mode_q != MODE_CONT) && trig;
        wr_en     = !arm && (((state_q == ST_PRETRIG) && !stop_now) ||
                             (state_q == ST_POSTTRIG));
        armed     = (state_q == ST_PRETRIG) || (state_q == ST_POSTTRIG);
        done      = (state_q == ST_FROZEN);
        cur_mode  = mode_q;
    end

    // capture bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= MODE_AFTER;
            remain_q  <= '0;
            trig_hit  <= 1'b0;
            trig_addr <= '0;
        end else if (arm) begin
            mode_q    <= cap_mode_e'(mode_in);
            remain_q  <= '0;
            trig_hit  <= 1'b0;
            trig_addr <= '0;
        end else if (take_trig) begin
            remain_q  <= tail_len;
            trig_hit  <= 1'b1;
            trig_addr <= wr_ptr;
        end else if (state_q == ST_POSTTRIG) begin
            remain_q  <= remain_q - CW'(1);
        end
    end
endmodule

// File: rtl/cap_store.sv
module cap_store #(
    parameter int PROBE_W = 8,
    parameter int DEPTH   = 64,
    parameter int AW      = 6,
    parameter int CW      = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [PROBE_W-1:0] wdata,
    input  logic [AW-1:0]      rd_phys,
    output logic [AW-1:0]      wr_ptr,
    output logic [CW-1:0]      fill,
    output logic [PROBE_W-1:0] rdata
);
    logic [PROBE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            fill   <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            fill   <= '0;
        end else if (wr_en) begin
            wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (fill != CW'(DEPTH)) fill <= fill + CW'(1);
        end
    end

    assign rdata = mem[rd_phys];
endmodule

// File: rtl/cap_rdmap.sv
module cap_rdmap #(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int CW    = 7
) (
    input  logic [AW-1:0] wr_ptr,
    input  logic [CW-1:0] fill,
    input  logic [AW-1:0] rd_idx,
    output logic [AW-1:0] rd_phys
);
    logic [AW-1:0] oldest;
    logic [AW:0]   sum;

    always_comb begin
        oldest  = (fill == CW'(DEPTH)) ? wr_ptr : '0;
        sum     = {1'b0, oldest} + {1'b0, rd_idx};
        rd_phys = (sum >= (AW+1)'(DEPTH)) ? AW'(sum - (AW+1)'(DEPTH)) : sum[AW-1:0];
    end
endmodule

// File: rtl/trig_capture_buf.sv
module trig_capture_buf
    import cap_pkg::*;
#(
    parameter int PROBE_W = 8,
    parameter int DEPTH   = 64,
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic               stop,
    input  logic               trig,
    input  logic [1:0]         mode,
    input  logic [PROBE_W-1:0] probe,
    input  logic [AW-1:0]      rd_idx,
    output logic               armed,
    output logic               done,
    output logic               trig_hit,
    output logic [AW-1:0]      trig_addr,
    output logic [CW-1:0]      valid_cnt,
    output logic [PROBE_W-1:0] rd_data
);
    logic          wr_en;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_phys;
    cap_mode_e     cur_mode;

    cap_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .arm(arm), .stop(stop), .trig(trig),
        .mode_in(mode), .wr_ptr(wr_ptr), .wr_en(wr_en), .armed(armed),
        .done(done), .trig_hit(trig_hit), .trig_addr(trig_addr),
        .cur_mode(cur_mode)
    );

    cap_store #(.PROBE_W(PROBE_W), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(arm), .wr_en(wr_en), .wdata(probe),
        .rd_phys(rd_phys), .wr_ptr(wr_ptr), .fill(valid_cnt), .rdata(rd_data)
    );

    cap_rdmap #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_rdmap (
        .wr_ptr(wr_ptr), .fill(valid_cnt), .rd_idx(rd_idx), .rd_phys(rd_phys)
    );
endmodule

// File: rtl/cap_chk.sv
module cap_chk
    import cap_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arm,
    input logic          armed,
    input logic          done,
    input logic          trig_hit,
    input logic [AW-1:0] trig_addr,
    input logic [CW-1:0] valid_cnt,
    input logic          wr_en,
    input cap_mode_e     cur_mode
);
    assert_arm_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (armed && !done && valid_cnt == '0 && !trig_hit));

    assert_fill_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && valid_cnt < CW'(DEPTH)) |=> (valid_cnt == $past(valid_cnt) + CW'(1)));

    assert_fill_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_cnt <= CW'(DEPTH));

    assert_done_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !armed);

    assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> (done && $stable(valid_cnt) && $stable(trig_addr)));

    assert_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en);

    assert_cont_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cur_mode == MODE_CONT) |-> !trig_hit);
endmodule

bind trig_capture_buf cap_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .arm(arm), .armed(armed), .done(done),
    .trig_hit(trig_hit), .trig_addr(trig_addr), .valid_cnt(valid_cnt),
    .wr_en(wr_en), .cur_mode(cur_mode)
);

// File: tb/sim_trig_capture_buf.sv
`timescale 1ns/1ps
module sim_trig_capture_buf;
    localparam int W  = 12;
    localparam int D  = 20;
    localparam int AW = $clog2(D);
    localparam int CW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0, stop = 1'b0, trig = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [W-1:0]  probe = '0;
    logic [AW-1:0] rd_idx = '0;
    logic          armed, done, trig_hit;
    logic [AW-1:0] trig_addr;
    logic [CW-1:0] valid_cnt;
    logic [W-1:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [W-1:0] hist [512];

    always #2.5 clk = ~clk;

    trig_capture_buf #(.PROBE_W(W), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .arm(arm), .stop(stop), .trig(trig),
        .mode(mode), .probe(probe), .rd_idx(rd_idx), .armed(armed),
        .done(done), .trig_hit(trig_hit), .trig_addr(trig_addr),
        .valid_cnt(valid_cnt), .rd_data(rd_data)
    );

    function automatic int tail_of(int m);
        if (m == 0) return (D * 88) / 100;
        if (m == 1) return D / 2;
        if (m == 2) return (D * 12) / 100;
        return 0;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_readout(int n, string req);
        int valid = (n < D) ? n : D;
        int bad = -1;
        int act = 0, exp = 0;
        for (int i = 0; i < valid; i++) begin
            @(negedge clk);
            rd_idx = AW'(i);
            #1;
            if (bad < 0 && rd_data !== hist[n - valid + i]) begin
                bad = i; act = int'(rd_data); exp = int'(hist[n - valid + i]);
            end
        end
        chk(bad < 0, req, act, exp);
    endtask

    // m: mode, tk: trigger write index (ignored in continuous), sk: stop index (continuous)
    task automatic run(int m, int tk, int sk);
        int n = (m == 3) ? sk : tk + 1 + tail_of(m);
        int loops = (m == 3) ? sk + 1 : n;
        bit early_done = 0, lost_arm = 0;
        @(negedge clk);
        mode = 2'(m); arm = 1'b1; trig = 1'b0; stop = 1'b0;
        @(posedge clk);
        for (int k = 0; k < loops; k++) begin
            @(negedge clk);
            arm = 1'b0;
            if (done) early_done = 1;
            if (!armed) lost_arm = 1;
            mode  = 2'($urandom_range(0, 3));        // R1: ignored after arm
            probe = W'($urandom);
            if (m == 3) begin
                trig = 1'($urandom);                  // R9: ignored
                stop = (k == sk);
            end else begin
                trig = (k == tk) || (k > tk && 1'($urandom));
                stop = 1'($urandom);                  // R10: ignored
            end
            hist[k] = probe;
        end
        @(negedge clk);
        trig = 1'b0; stop = 1'b0;
        chk(!early_done && !lost_arm, "R5 no early done", int'(early_done), 0);
        chk(done && !armed, (m == 3) ? "R9 done after stop" : "R5 done after tail", int'(done), 1);
        chk(valid_cnt == CW'((n < D) ? n : D), (n < D) ? "R8 valid count" : "R2 valid count",
            int'(valid_cnt), (n < D) ? n : D);
        if (m == 3) begin
            chk(!trig_hit, "R9 trig_hit stays low", int'(trig_hit), 0);
        end else begin
            chk(trig_hit, "R4 trig_hit", int'(trig_hit), 1);
            chk(trig_addr == AW'(tk % D), "R4 trig_addr", int'(trig_addr), tk % D);
            chk((n - tk - 1) == tail_of(m), "R3 tail length", n - tk - 1, tail_of(m));
        end
        check_readout(n, (n < D) ? "R8 readout" : "R7 readout");
        // frozen: activity must not touch the capture
        begin
            int vc = int'(valid_cnt);
            int ta = int'(trig_addr);
            for (int j = 0; j < 6; j++) begin
                @(negedge clk);
                probe = W'($urandom); trig = 1'($urandom); stop = 1'($urandom);
            end
            @(negedge clk);
            trig = 1'b0; stop = 1'b0;
            chk(done && int'(valid_cnt) == vc && int'(trig_addr) == ta,
                "R6 frozen state", int'(valid_cnt), vc);
            check_readout(n, "R6 frozen readout");
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!armed && !done && valid_cnt == '0 && !trig_hit, "R1 reset state",
            int'(armed) + int'(done), 0);

        // arm clears
        @(negedge clk); arm = 1'b1;
        @(negedge clk); arm = 1'b0;
        chk(armed && !done && valid_cnt == '0, "R1 arm state", int'(valid_cnt), 0);

        // directed corners
        run(1, 0, 0);          // R8 trigger on first sample
        run(0, 45, 0);         // R7 wrap, mostly-after
        run(2, 3, 0);          // R8 early trigger, short tail
        run(2, 57, 0);         // R7 many wraps
        run(3, 0, 7);          // R9 stop before full
        run(3, 0, 43);         // R9 stop after wraps

        // R11: restart mid-capture
        @(negedge clk); mode = 2'd1; arm = 1'b1;
        @(negedge clk); arm = 1'b0;
        repeat (9) @(negedge clk) probe = W'($urandom);
        run(1, 2, 0);
        chk(valid_cnt == CW'(13), "R11 restart discards", int'(valid_cnt), 13);

        // random mix
        for (int r = 0; r < 10; r++) begin
            int m = $urandom_range(0, 3);
            if (m == 3) run(3, 0, $urandom_range(1, 3 * D));
            else        run(m, $urandom_range(0, 3 * D), 0);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule